// File: doc/BRIEF.md
# Variable-Width Reloadable Interval Timer

This block is an interval timer clocked by CPU cycles. It holds a 16-bit down-counter and a 16-bit reload register. The CPU fills the reload register four bits at a time through a narrow write port. A separate write copies the reload register into the counter. A control register turns counting on or off. It also picks how many low-order bits take part in counting: all 16, the low 12, the low 8 or the low 4. The bits above that field are frozen while the counter runs. When the active field passes from all zeros to all ones, the block latches an interrupt request. The request stays asserted until the CPU acknowledges it.

The host sees only a write strobe with a 16-bit address and a 4-bit data value, plus a clock enable that pulses once per CPU cycle. Address bits 15..12 pick the register page: 0xE for the reload nibbles and 0xF for the command and control registers. Address bits 1..0 pick the register within the page. All other address bits are ignored, so each register appears at many mirror addresses.

Top module: `irq_interval_timer`

## Requirements
- R1: After a synchronous active-low reset, the counter, reload register and control register are all zero and `irq_out` is low.
- R2: A write with address bits 15..12 = 0xE loads one reload nibble. Address bits 1..0 = 0, 1, 2, 3 pick reload bits 3..0, 7..4, 11..8, 15..12 respectively. Address bits 11..2 are not decoded.
- R3: A write with address bits 15..12 = 0xF and bits 1..0 = 1 sets the control register. Data bit 0 is the count enable. Data bits 3..1 are the width code: 000 counts bits 15..0, 001 counts bits 11..0, 010 or 011 counts bits 7..0, and 1xx counts bits 3..0.
- R4: The counter decrements by one on a clock edge only when `cpu_cycle_en` is high and the count enable is set. Otherwise it holds its value.
- R5: Counter bits above the active field never change while counting. A borrow out of the field is not passed into them.
- R6: When the counter decrements while its active field is zero, the field becomes all ones and `irq_out` goes high one cycle later.
- R7: A write with address bits 15..12 = 0xF and bits 1..0 = 0 copies all 16 reload bits into the counter, whatever the width code. It takes priority over a decrement in the same cycle.
- R8: A write to page 0xF with address bits 1..0 equal to 0 or 1 clears `irq_out`. A wrap in that same cycle leaves it set. Writes with bits 1..0 equal to 2 or 3 do not clear it.
- R9: Once set, `irq_out` stays high, whether or not counting continues, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_cycle_en | input | 1 | One-cycle pulse per CPU cycle; gates counting |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 4 | Write data nibble |
| irq_out | output | 1 | Interrupt request, active high, held until acknowledged |

## Verification
On every cycle, assertions check four things. The counter holds when it is not stepping. The frozen bits stay unchanged across a decrement. A command write loads the reload value exactly. The interrupt flag sets, clears and holds by the rules in R8 and R9. Behaviours that depend on counted intervals can only be shown by the directed scenarios, which measure the number of enabled cycles to an interrupt. Those behaviours are the width-code decode with both aliases of the 8-bit and 4-bit codes, the absence of borrow into frozen bits over a following wrap, full-width reload while a narrow width is selected, and address mirroring.

// File: rtl/irqtmr_pkg.sv
// Package: shared types and helpers for the interval timer.
// Assumes the counter is built from 4-bit nibbles and the width code is 3 bits.
package irqtmr_pkg;

    // Control register contents: width code over the enable bit.
    typedef struct packed {
        logic [2:0] width_code;
        logic       enable;
    } ctrl_t;

    // Number of low nibbles that take part in counting for a width code,
    // limited to the number of nibbles the counter really has.
    function automatic int unsigned field_nibbles(input logic [2:0] code,
                                                  input int unsigned max_nib);
        int unsigned n;
        casez (code)
            3'b000:  n = 4;
            3'b001:  n = 3;
            3'b01?:  n = 2;
            default: n = 1;
        endcase
        if (n > max_nib) n = max_nib;
        return n;
    endfunction

endpackage

// File: rtl/irqtmr_regs.sv
// Register decode: the reload nibble registers and the control register,
// plus single-cycle load and acknowledge strobes.
// Assumes the page is given by the top four address bits and the register
// by the lowest SEL_W bits; no other address bits are looked at.
module irqtmr_regs
    import irqtmr_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          CNT_W       = 16,
    parameter int          NIB_W       = 4,
    parameter logic [3:0]  RELOAD_PAGE = 4'hE,
    parameter logic [3:0]  CMD_PAGE    = 4'hF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NIB_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  reload_q,
    output ctrl_t             ctrl_q,
    output logic              load_pulse,
    output logic              ack_pulse
);
    localparam int NIBBLES = CNT_W / NIB_W;
    localparam int SEL_W   = (NIBBLES > 1) ? $clog2(NIBBLES) : 1;

    logic [3:0]       page;
    logic [SEL_W-1:0] sel;
    logic             reload_hit;
    logic             cmd_hit;
    logic             ctrl_wr;

    // Split the address into page and register select.
    assign page       = wr_addr[ADDR_W-1 -: 4];
    assign sel        = wr_addr[SEL_W-1:0];
    assign reload_hit = wr_en && (page == RELOAD_PAGE);
    assign cmd_hit    = wr_en && (page == CMD_PAGE);
    assign ctrl_wr    = cmd_hit && (sel == SEL_W'(1));
    assign load_pulse = cmd_hit && (sel == SEL_W'(0));
    assign ack_pulse  = load_pulse || ctrl_wr;

    // One storage register per reload nibble.
    for (genvar i = 0; i < NIBBLES; i++) begin : g_reload
        logic [NIB_W-1:0] nib_q;

        // Capture the nibble written to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                nib_q <= '0;
            else if (reload_hit && (sel == SEL_W'(i)))
                nib_q <= wr_data;
        end

        assign reload_q[i*NIB_W +: NIB_W] = nib_q;
    end

    // Capture the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (ctrl_wr)
            ctrl_q <= '{width_code: wr_data[3:1], enable: wr_data[0]};
    end

    // R3
    ctrl_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ctrl_q.enable == $past(wr_data[0])) &&
                    (ctrl_q.width_code == $past(wr_data[3:1])));

    // R2
    reload_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reload_hit |=> $stable(reload_q));

endmodule

// File: rtl/irqtmr_counter.sv
// Down-counter with a selectable active field of low nibbles.
// Nibbles above the field are frozen; the borrow chain stops at the field
// top. Reports a wrap when a step is taken with the field at zero.
// Assumes load has priority over step.
module irqtmr_counter
    import irqtmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    input  logic [2:0]       width_code,
    output logic             wrap
);
    localparam int NIBBLES = CNT_W / NIB_W;

    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cnt_d;
    logic [CNT_W-1:0]   field_mask;
    logic [NIBBLES-1:0] nib_active;
    logic [NIBBLES:0]   borrow;
    logic               step;
    logic               field_zero;
    int unsigned        active_n;

    // Width of the active field in nibbles.
    assign active_n  = field_nibbles(width_code, NIBBLES);
    assign borrow[0] = 1'b1;

    // Per-nibble decrement with a borrow chain bounded by the field.
    for (genvar i = 0; i < NIBBLES; i++) begin : g_nib
        logic [NIB_W-1:0] nib;
        assign nib           = cnt_q[i*NIB_W +: NIB_W];
        assign nib_active[i] = (i < active_n);
        assign field_mask[i*NIB_W +: NIB_W] = {NIB_W{nib_active[i]}};
        assign cnt_d[i*NIB_W +: NIB_W] =
            (nib_active[i] && borrow[i]) ? nib - 1'b1 : nib;
        assign borrow[i+1] = borrow[i] && nib_active[i] && (nib == '0);
    end

    assign step       = count_en && !load;
    assign field_zero = ((cnt_q & field_mask) == '0);
    assign wrap       = step && field_zero;

    // Counter register: reload first, then step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= reload;
        else if (step)
            cnt_q <= cnt_d;
    end

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(cnt_q));

    // R5
    frozen_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ((cnt_q & ~$past(field_mask)) ==
                  ($past(cnt_q) & ~$past(field_mask))));

    // R6
    wrap_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ((cnt_q & $past(field_mask)) == $past(field_mask)));

    // R7
    full_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(reload)));

endmodule

// File: rtl/irqtmr_flag.sv
// Interrupt pending flag: set by a wrap, cleared by an acknowledge,
// set winning when both arrive together.
module irqtmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    output logic irq
);
    // Hold the pending state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (set)
            irq <= 1'b1;
        else if (ack)
            irq <= 1'b0;
    end

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> irq);

    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !set) |=> !irq);

    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && !ack) |=> $stable(irq));

endmodule

// File: rtl/irq_interval_timer.sv
// Top level of the interval timer: register decode, the field-limited
// down-counter and the interrupt flag.
// Assumes cpu_cycle_en is a synchronous qualifier in the clk domain.
module irq_interval_timer
    import irqtmr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_cycle_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NIB_W-1:0]  wr_data,
    output logic              irq_out
);
    logic [CNT_W-1:0] reload_q;
    ctrl_t            ctrl_q;
    logic             load_pulse;
    logic             ack_pulse;
    logic             count_en;
    logic             wrap;

    irqtmr_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .NIB_W  (NIB_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .reload_q   (reload_q),
        .ctrl_q     (ctrl_q),
        .load_pulse (load_pulse),
        .ack_pulse  (ack_pulse)
    );

    // Count only on CPU cycles while enabled.
    assign count_en = cpu_cycle_en && ctrl_q.enable;

    irqtmr_counter #(
        .CNT_W (CNT_W),
        .NIB_W (NIB_W)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_en   (count_en),
        .load       (load_pulse),
        .reload     (reload_q),
        .width_code (ctrl_q.width_code),
        .wrap       (wrap)
    );

    irqtmr_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (wrap),
        .ack   (ack_pulse),
        .irq   (irq_out)
    );

endmodule

// File: tb/irq_interval_timer_test.sv
`timescale 1ns/1ps
module irq_interval_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_cycle_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [3:0]  wr_data = '0;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    irq_interval_timer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_cycle_en (cpu_cycle_en),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .irq_out      (irq_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic exp);
        checks++;
        if (irq_out !== exp) begin
            fails++;
            $display("FAIL %s: irq_out=%b expected %b at %0t", req, irq_out, exp, $time);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_ce(input logic [15:0] a, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; cpu_cycle_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cpu_cycle_en = 1'b0;
    endtask

    task automatic run(input int n);
        @(negedge clk);
        cpu_cycle_en = 1'b1;
        repeat (n) @(negedge clk);
        cpu_cycle_en = 1'b0;
    endtask

    task automatic load16(input logic [15:0] v);
        wr(16'hE000, v[3:0]);
        wr(16'hE001, v[7:4]);
        wr(16'hE002, v[11:8]);
        wr(16'hE003, v[15:12]);
        wr(16'hF000, 4'h0);
    endtask

    // R1: reset state
    task automatic t_reset();
        check("R1 irq low after reset", 1'b0);
        run(20);
        check("R1 control clear, no count", 1'b0);
        wr(16'hF001, 4'b0001);
        run(1);
        check("R1 counter zero wraps on first step", 1'b1);
        wr(16'hF000, 4'h0);
        check("R8 F000 write acks", 1'b0);
        run(1);
        check("R1 reload zero wraps on first step", 1'b1);
    endtask

    // R2 R4 R6 R9: full width count
    task automatic t_full();
        wr(16'hF001, 4'b0001);
        load16(16'h0005);
        run(5);
        check("R6 no irq before wrap (16-bit)", 1'b0);
        run(1);
        check("R6 irq at wrap (16-bit)", 1'b1);
        run(10);
        check("R9 irq held while counting", 1'b1);
        wr(16'hF001, 4'b0000);
        run(5);
        check("R8 F001 write acks", 1'b0);
    endtask

    // R3: 12-bit field
    task automatic t_w12();
        wr(16'hF001, 4'b0011);
        load16(16'hF003);
        run(3);
        check("R3 12-bit no irq early", 1'b0);
        run(1);
        check("R3 12-bit irq at wrap", 1'b1);
    endtask

    // R3 R5 R8: 8-bit field, both codes
    task automatic t_w8();
        wr(16'hF001, 4'b0101);
        load16(16'hAB02);
        run(2);
        check("R3 8-bit no irq early", 1'b0);
        run(1);
        check("R3 8-bit irq at wrap", 1'b1);
        wr(16'hF001, 4'b0111);
        check("R8 ack via control write", 1'b0);
        run(255);
        check("R5 8-bit alias period 256 minus one", 1'b0);
        run(1);
        check("R5 8-bit alias wraps after 256", 1'b1);
    endtask

    // R5: borrow stays inside a 4-bit field
    task automatic t_w4();
        wr(16'hF001, 4'b1001);
        load16(16'h0102);
        run(2);
        check("R3 4-bit no irq early", 1'b0);
        run(1);
        check("R3 4-bit irq at wrap", 1'b1);
        wr(16'hF001, 4'b0101);
        run(15);
        check("R5 high bits frozen, no early irq", 1'b0);
        run(1);
        check("R5 high bits frozen, field 0x0F wraps", 1'b1);
        wr(16'hF001, 4'b1111);
        load16(16'h00F1);
        run(1);
        check("R3 code 111 is 4-bit, no irq", 1'b0);
        run(1);
        check("R3 code 111 is 4-bit, wraps", 1'b1);
    endtask

    // R4: pause and clock enable gating
    task automatic t_pause();
        wr(16'hF001, 4'b0000);
        load16(16'h0002);
        run(50);
        check("R4 disabled does not count", 1'b0);
        wr(16'hF001, 4'b0001);
        repeat (10) @(negedge clk);
        check("R4 no count without cpu_cycle_en", 1'b0);
        run(2);
        check("R4 counted exactly two", 1'b0);
        run(1);
        check("R4 wrap after third step", 1'b1);
    endtask

    // R7: reload copies all bits and wins over a step
    task automatic t_reload();
        wr(16'hF001, 4'b0001);
        load16(16'hAB00);
        wr(16'hF001, 4'b1001);
        load16(16'h0005);
        wr(16'hF001, 4'b0001);
        run(5);
        check("R7 full 16-bit reload in 4-bit mode", 1'b0);
        run(1);
        check("R7 reloaded value wraps on time", 1'b1);
        load16(16'h0003);
        wr_ce(16'hF000, 4'h0);
        run(3);
        check("R7 reload wins over step", 1'b0);
        run(1);
        check("R7 wrap after reload priority", 1'b1);
    endtask

    // R2 R8: address mirrors and non-acking writes
    task automatic t_mirror();
        wr(16'hF0F1, 4'b0001);
        load16(16'hFFFF);
        wr(16'hEFF0, 4'h2);
        wr(16'hE7F1, 4'h0);
        wr(16'hE0F6, 4'h0);
        wr(16'hEAB3, 4'h0);
        wr(16'hF5F0, 4'h0);
        run(2);
        check("R2 mirrored reload writes", 1'b0);
        run(1);
        check("R2 mirrored reload wraps on time", 1'b1);
        wr(16'hF002, 4'h3);
        wr(16'hF003, 4'h5);
        check("R8 F002/F003 writes do not ack", 1'b1);
    endtask

    // R8: wrap and ack in one cycle
    task automatic t_ack_race();
        wr(16'hF001, 4'b1001);
        load16(16'h0000);
        check("R8 irq clear before race", 1'b0);
        wr_ce(16'hF001, 4'b1001);
        check("R8 wrap beats same-cycle ack", 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full();
        t_w12();
        t_w8();
        t_w4();
        t_pause();
        t_reload();
        t_mirror();
        t_ack_race();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule